// File: doc/BRIEF.md
# Guest Context Entry and Exit Sequencer

This block carries out the two halves of an interpreted-guest switch. An entry request carries the word address of a control block in memory. The sequencer first copies the eight live context words from the register-file port into the block's host-save area. It then reads the eight guest words from the block's guest area into the register file. From then on the guest runs, and the block watches a stream of classified guest instructions and events. When an event class has its bit set in the interception mask, the exit sequence runs. It writes the live context back into the same guest area, reloads the host context from the host-save area, wipes the host-save area to zero, and publishes a 4-bit reason code. Software waiting on the entry instruction then continues with the instruction that follows it.

The control block can sit at any word address, and its address is taken as an operand on every entry. Nested or repeated entries therefore never collide on a fixed save area. Re-running the entry with the same pointer resumes the guest from the words the last exit left behind. Within a block of `2*NCTX` words, the guest area occupies offsets 0 to NCTX-1 and the host-save area occupies offsets NCTX to 2*NCTX-1.

The state machine has seven states. IDLE goes to HOST_OUT when an entry is accepted. HOST_OUT goes to GUEST_IN after the last host word is stored. GUEST_IN goes to RUN when its last word is loaded, or to GUEST_OUT if an exit is already pending. RUN goes to GUEST_OUT on an intercepted event. GUEST_OUT goes to HOST_IN after the last guest word is stored. HOST_IN goes to WIPE after the last host word is reloaded. WIPE goes to IDLE after the last zero is written.

Top module: `gx_guest_seq`

## Requirements
- R1: After reset the block is idle: busy, guest_active, exit_done and exit_code are all 0, and it drives no memory or context writes.
- R2: On an accepted entry with pointer P, context word i (i = 0..7) is written to memory address P+8+i, one word per cycle.
- R3: After the host save, memory word P+i is loaded into context word i. busy is high for exactly 17 cycles of the entry, and guest_active then rises.
- R4: An entry request is ignored while a sequence runs or while the guest is active. No memory at the second pointer changes, and the running entry completes unchanged.
- R5: While the guest is active, an event of class c (1..15) causes an exit only if mask bit c is 1. Class 0, or a class with a clear mask bit, leaves guest_active high. Events are ignored while idle.
- R6: On exit, context word i is written back to memory address P+i.
- R7: On exit, context word i is restored from memory address P+8+i.
- R8: When the exit completes, memory words P+8..P+15 are all zero.
- R9: An exit keeps busy high for exactly 25 cycles. In the first idle cycle exit_done pulses and exit_code equals the intercepted class. exit_code reads 0 from the next accepted entry until the following exit.
- R10: Entering again with the same pointer after an exit loads the guest words that the exit stored.
- R11: An intercepted event that arrives during the entry sequence is held. The exit starts directly after the guest load, busy stays high for 42 cycles in total, guest_active never rises, and exit_code gives the held class.
- R12: No memory or context write occurs while the block is idle or the guest is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | One-cycle entry request |
| enter_ptr | input | AW | Control-block word address, taken with enter_req |
| icpt_mask | input | NCLS | Interception mask, bit c for event class c |
| evt_valid | input | 1 | Guest event present this cycle |
| evt_class | input | CODEW | Class of the guest event |
| ctx_idx | output | IW | Context word selected for read or write |
| ctx_we | output | 1 | Context write strobe |
| ctx_wdata | output | DW | Context write data |
| ctx_rdata | input | DW | Context word at ctx_idx, same cycle |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data valid one cycle later |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | A save or load sequence is running |
| guest_active | output | 1 | The guest context is live |
| exit_done | output | 1 | One-cycle pulse when an exit completes |
| exit_code | output | CODEW | Exit reason, 0 when no exit is reported |

## Verification
The assertions assume three things about the environment. The register file returns the selected word in the same cycle. Memory returns read data exactly one cycle after mem_re. Nothing else writes the control block while a sequence runs. The bench's memory and register-file models meet these conditions. The bench changes context words only while the guest is active and loads memory only while the block is idle. It drives every request and event on the falling edge, so each one is sampled by exactly one rising edge.

// File: rtl/gx_pkg.sv
package gx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOST_OUT,
        ST_GUEST_IN,
        ST_RUN,
        ST_GUEST_OUT,
        ST_HOST_IN,
        ST_WIPE
    } gx_state_e;
endpackage

// File: rtl/gx_step_ctr.sv
module gx_step_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/gx_icpt_filter.sv
module gx_icpt_filter #(
    parameter int NCLS  = 16,
    parameter int CODEW = 4
) (
    input  logic [NCLS-1:0]  icpt_mask,
    input  logic             evt_valid,
    input  logic [CODEW-1:0] evt_class,
    output logic             hit
);
    always_comb begin
        hit = evt_valid && (evt_class != '0) && icpt_mask[evt_class];
    end
endmodule

// File: rtl/gx_xfer_path.sv
module gx_xfer_path
    import gx_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 8,
    parameter int NCTX = 8,
    parameter int CW   = 4,
    parameter int IW   = 3
) (
    input  gx_state_e         state,
    input  logic [CW-1:0]     cnt,
    input  logic [AW-1:0]     base,
    input  logic [DW-1:0]     ctx_rdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [IW-1:0]     ctx_idx,
    output logic              ctx_we,
    output logic [DW-1:0]     ctx_wdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     mem_wdata
);
    localparam logic [AW-1:0] HOST_OFS = AW'(NCTX);

    logic [AW-1:0] guest_at;
    logic [AW-1:0] host_at;
    logic [IW-1:0] lag_idx;
    logic          rd_phase;

    always_comb begin
        guest_at = base + AW'(cnt);
        host_at  = base + HOST_OFS + AW'(cnt);
        lag_idx  = IW'(cnt - CW'(1));
        rd_phase = (cnt < CW'(NCTX));
    end

    always_comb begin
        ctx_idx   = '0;
        ctx_we    = 1'b0;
        ctx_wdata = mem_rdata;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = ctx_rdata;
        unique case (state)
            ST_HOST_OUT: begin
                ctx_idx  = IW'(cnt);
                mem_addr = host_at;
                mem_we   = 1'b1;
            end
            ST_GUEST_IN: begin
                mem_addr = guest_at;
                mem_re   = rd_phase;
                ctx_idx  = lag_idx;
                ctx_we   = (cnt != '0);
            end
            ST_GUEST_OUT: begin
                ctx_idx  = IW'(cnt);
                mem_addr = guest_at;
                mem_we   = 1'b1;
            end
            ST_HOST_IN: begin
                mem_addr = host_at;
                mem_re   = rd_phase;
                ctx_idx  = lag_idx;
                ctx_we   = (cnt != '0);
            end
            ST_WIPE: begin
                mem_addr  = host_at;
                mem_we    = 1'b1;
                mem_wdata = '0;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gx_guest_seq.sv
module gx_guest_seq
    import gx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int NCTX  = 8,
    parameter int NCLS  = 16,
    parameter int CODEW = $clog2(NCLS),
    parameter int IW    = $clog2(NCTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic [AW-1:0]    enter_ptr,
    input  logic [NCLS-1:0]  icpt_mask,
    input  logic             evt_valid,
    input  logic [CODEW-1:0] evt_class,
    output logic [IW-1:0]    ctx_idx,
    output logic             ctx_we,
    output logic [DW-1:0]    ctx_wdata,
    input  logic [DW-1:0]    ctx_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic             mem_re,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             guest_active,
    output logic             exit_done,
    output logic [CODEW-1:0] exit_code
);
    localparam int CW = $clog2(NCTX + 1);
    localparam logic [CW-1:0] LAST_ST = CW'(NCTX - 1);
    localparam logic [CW-1:0] LAST_LD = CW'(NCTX);

    gx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt;
    logic             cnt_clr, cnt_inc;
    logic             hit;
    logic [AW-1:0]    base_q;
    logic             pend_q;
    logic [CODEW-1:0] cause_q;
    logic             exit_done_q;
    logic [CODEW-1:0] exit_code_q;
    logic             st_last, ld_last;
    logic             in_entry;

    gx_step_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    gx_icpt_filter #(.NCLS(NCLS), .CODEW(CODEW)) u_filt (
        .icpt_mask (icpt_mask),
        .evt_valid (evt_valid),
        .evt_class (evt_class),
        .hit       (hit)
    );

    gx_xfer_path #(.DW(DW), .AW(AW), .NCTX(NCTX), .CW(CW), .IW(IW)) u_path (
        .state     (state_q),
        .cnt       (cnt),
        .base      (base_q),
        .ctx_rdata (ctx_rdata),
        .mem_rdata (mem_rdata),
        .ctx_idx   (ctx_idx),
        .ctx_we    (ctx_we),
        .ctx_wdata (ctx_wdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        st_last  = (cnt == LAST_ST);
        ld_last  = (cnt == LAST_LD);
        in_entry = (state_q == ST_HOST_OUT) || (state_q == ST_GUEST_IN);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (enter_req) state_d = ST_HOST_OUT;
            ST_HOST_OUT:  if (st_last)   state_d = ST_GUEST_IN;
            ST_GUEST_IN:  if (ld_last)   state_d = (pend_q || hit) ? ST_GUEST_OUT : ST_RUN;
            ST_RUN:       if (hit)       state_d = ST_GUEST_OUT;
            ST_GUEST_OUT: if (st_last)   state_d = ST_HOST_IN;
            ST_HOST_IN:   if (ld_last)   state_d = ST_WIPE;
            ST_WIPE:      if (st_last)   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
        cnt_clr = (state_d != state_q);
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            base_q      <= '0;
            pend_q      <= 1'b0;
            cause_q     <= '0;
            exit_done_q <= 1'b0;
            exit_code_q <= '0;
        end else begin
            state_q     <= state_d;
            exit_done_q <= (state_q == ST_WIPE) && st_last;
            if (state_q == ST_IDLE && enter_req) begin
                base_q      <= enter_ptr;
                exit_code_q <= '0;
                pend_q      <= 1'b0;
            end
            if (in_entry && hit && !pend_q) begin
                pend_q  <= 1'b1;
                cause_q <= evt_class;
            end
            if (state_q == ST_RUN && hit) begin
                cause_q <= evt_class;
            end
            if (state_d == ST_GUEST_OUT && state_q != ST_GUEST_OUT) begin
                pend_q <= 1'b0;
            end
            if (state_q == ST_WIPE && st_last) begin
                exit_code_q <= cause_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b0;
        guest_active = 1'b0;
        cnt_inc      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_RUN:   guest_active = 1'b1;
            default: begin
                busy    = 1'b1;
                cnt_inc = 1'b1;
            end
        endcase
        exit_done = exit_done_q;
        exit_code = exit_code_q;
    end
endmodule

// File: rtl/gx_seq_chk.sv
module gx_seq_chk #(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int CODEW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enter_req,
    input logic             ctx_we,
    input logic             mem_we,
    input logic             mem_re,
    input logic [DW-1:0]    mem_wdata,
    input logic             busy,
    input logic             guest_active,
    input logic             exit_done,
    input logic [CODEW-1:0] exit_code
);
    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && guest_active)); // R3
    AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(guest_active)) |-> $past(enter_req)); // R4
    AST_GUEST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        guest_active |-> (exit_code == '0)); // R9
    AST_DONE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_done |-> (exit_code != '0)); // R9
    AST_WIPE_LAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        exit_done |-> ($past(mem_we) && ($past(mem_wdata) == '0))); // R8
    AST_QUIET_OUTSIDE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !ctx_we)); // R12
    AST_GUEST_EXIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guest_active) |-> busy); // R5
endmodule

bind gx_guest_seq gx_seq_chk #(.DW(DW), .AW(AW), .CODEW(CODEW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req    (enter_req),
    .ctx_we       (ctx_we),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .mem_wdata    (mem_wdata),
    .busy         (busy),
    .guest_active (guest_active),
    .exit_done    (exit_done),
    .exit_code    (exit_code)
);

// File: tb/tb_gx_guest_seq.sv
`timescale 1ns/1ps
module tb_gx_guest_seq;
    localparam int DW = 32, AW = 8, NCTX = 8, NCLS = 16, CODEW = 4, IW = 3;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic             enter_req = 0;
    logic [AW-1:0]    enter_ptr = '0;
    logic [NCLS-1:0]  icpt_mask = '0;
    logic             evt_valid = 0;
    logic [CODEW-1:0] evt_class = '0;
    logic [IW-1:0]    ctx_idx;
    logic             ctx_we;
    logic [DW-1:0]    ctx_wdata, ctx_rdata;
    logic [AW-1:0]    mem_addr;
    logic             mem_we, mem_re;
    logic [DW-1:0]    mem_wdata, mem_rdata;
    logic             busy, guest_active, exit_done;
    logic [CODEW-1:0] exit_code;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] rf  [NCTX];
    logic          tb_mwe = 0, tb_rwe = 0;
    logic [AW-1:0] tb_maddr = '0;
    logic [IW-1:0] tb_ridx = '0;
    logic [DW-1:0] tb_data = '0;

    always_ff @(posedge clk) begin
        if (tb_mwe) mem[tb_maddr] <= tb_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (tb_rwe) rf[tb_ridx] <= tb_data;
        else if (ctx_we) rf[ctx_idx] <= ctx_wdata;
    end
    assign ctx_rdata = rf[ctx_idx];

    gx_guest_seq dut (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); tb_mwe = 1; tb_maddr = a; tb_data = d;
        @(negedge clk); tb_mwe = 0;
    endtask

    task automatic rwr(input int i, input logic [DW-1:0] d);
        @(negedge clk); tb_rwe = 1; tb_ridx = IW'(i); tb_data = d;
        @(negedge clk); tb_rwe = 0;
    endtask

    function automatic logic [DW-1:0] gval(input logic [AW-1:0] b, input int i);
        return {8'hA0, b, 8'h00, 8'(i)};
    endfunction
    function automatic logic [DW-1:0] hval(input logic [AW-1:0] b, input int i);
        return {8'h50, 8'(i), b, 8'h3C};
    endfunction

    // pulse enter at a negedge, then count negedges with busy high
    task automatic enter_count(input logic [AW-1:0] b, output int n);
        @(negedge clk); enter_req = 1; enter_ptr = b;
        @(negedge clk); enter_req = 0; n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic evt_count(input logic [CODEW-1:0] c, output int n);
        @(negedge clk); evt_valid = 1; evt_class = c;
        @(negedge clk); evt_valid = 0; n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    // vectors: {base, intercepted class, non-intercepted class}
    localparam logic [15:0] VEC [4] = '{
        {8'h10, 4'd3,  4'd7},
        {8'h40, 4'd1,  4'd2},
        {8'h90, 4'd15, 4'd14},
        {8'hE0, 4'd9,  4'd0}
    };

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, err;
        logic [AW-1:0] b;
        logic [CODEW-1:0] cin, cout;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !guest_active && !exit_done && exit_code == 0 && !mem_we && !ctx_we,
            "R1 reset idle", {busy, guest_active, exit_done, exit_code}, 0);

        // R5 event while idle ignored
        icpt_mask = '1;
        @(negedge clk); evt_valid = 1; evt_class = 4'd5;
        @(negedge clk); evt_valid = 0;
        chk(!busy && !guest_active, "R5 idle event ignored", {busy, guest_active}, 0);

        foreach (VEC[v]) begin
            b = VEC[v][15:8]; cin = VEC[v][7:4]; cout = VEC[v][3:0];
            icpt_mask = (16'h1 << cin) | 16'h0001;
            for (int i = 0; i < NCTX; i++) begin
                rwr(i, hval(b, i));
                mwr(b + AW'(i), gval(b, i));
                mwr(b + AW'(NCTX + i), 32'hDEAD_0000);
            end
            enter_count(b, n);
            chk(n == 17, "R3 entry busy length", n, 17);
            chk(guest_active, "R3 guest active", guest_active, 1);
            err = 0;
            for (int i = 0; i < NCTX; i++) if (mem[b + AW'(NCTX + i)] !== hval(b, i)) err++;
            chk(err == 0, "R2 host saved", err, 0);
            err = 0;
            for (int i = 0; i < NCTX; i++) if (rf[i] !== gval(b, i)) err++;
            chk(err == 0, "R3 guest loaded", err, 0);
            for (int i = 0; i < NCTX; i++) rwr(i, ~gval(b, i));
            // R5 non-intercepted class
            @(negedge clk); evt_valid = 1; evt_class = cout;
            @(negedge clk); evt_valid = 0;
            @(negedge clk);
            chk(guest_active && !busy, "R5 unmasked class ignored", guest_active, 1);
            evt_count(cin, n);
            chk(n == 25, "R9 exit busy length", n, 25);
            chk(exit_done && exit_code == cin, "R9 exit code", exit_code, cin);
            err = 0;
            for (int i = 0; i < NCTX; i++) if (mem[b + AW'(i)] !== ~gval(b, i)) err++;
            chk(err == 0, "R6 guest stored", err, 0);
            err = 0;
            for (int i = 0; i < NCTX; i++) if (rf[i] !== hval(b, i)) err++;
            chk(err == 0, "R7 host restored", err, 0);
            err = 0;
            for (int i = 0; i < NCTX; i++) if (mem[b + AW'(NCTX + i)] !== '0) err++;
            chk(err == 0, "R8 host area wiped", err, 0);
            @(negedge clk);
            chk(!exit_done && exit_code == cin, "R9 done single pulse", exit_done, 0);
        end

        // R10 resume same block (last vector base E0, class 9)
        b = 8'hE0;
        enter_count(b, n);
        err = 0;
        for (int i = 0; i < NCTX; i++) if (rf[i] !== ~gval(b, i)) err++;
        chk(err == 0 && guest_active, "R10 resume saved guest", err, 0);
        chk(exit_code == 0, "R9 code cleared on entry", exit_code, 0);
        // R4 entry while guest active ignored
        for (int i = 0; i < 16; i++) mwr(8'h60 + AW'(i), 32'h1111_0000 + i);
        @(negedge clk); enter_req = 1; enter_ptr = 8'h60;
        @(negedge clk); enter_req = 0;
        @(negedge clk);
        chk(guest_active && !busy, "R4 entry ignored in guest", busy, 0);
        // R5 class 0 never intercepts
        icpt_mask = '1;
        @(negedge clk); evt_valid = 1; evt_class = 4'd0;
        @(negedge clk); evt_valid = 0;
        @(negedge clk);
        chk(guest_active, "R5 class zero ignored", guest_active, 1);
        evt_count(4'd9, n);
        chk(n == 25 && exit_code == 9, "R9 exit after resume", exit_code, 9);

        // R4 entry request during an entry
        for (int i = 0; i < NCTX; i++) rwr(i, hval(8'h20, i));
        for (int i = 0; i < NCTX; i++) mwr(8'h20 + AW'(i), gval(8'h20, i));
        @(negedge clk); enter_req = 1; enter_ptr = 8'h20;
        @(negedge clk); enter_req = 0; n = 1;
        @(negedge clk); n++;
        @(negedge clk); enter_req = 1; enter_ptr = 8'h60; n++;
        @(negedge clk); enter_req = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == 17, "R4 entry unchanged", n, 17);
        err = 0;
        for (int i = 0; i < 16; i++) if (mem[8'h60 + AW'(i)] !== 32'h1111_0000 + i) err++;
        for (int i = 0; i < NCTX; i++) if (rf[i] !== gval(8'h20, i)) err++;
        chk(err == 0, "R4 second pointer untouched", err, 0);
        icpt_mask = 16'h0010;
        evt_count(4'd4, n);
        chk(n == 25 && rf[0] == hval(8'h20, 0), "R7 exit after ignored entry", rf[0], hval(8'h20, 0));

        // R11 event held during entry
        for (int i = 0; i < NCTX; i++) rwr(i, hval(8'h30, i));
        for (int i = 0; i < NCTX; i++) mwr(8'h30 + AW'(i), gval(8'h30, i));
        icpt_mask = 16'h0040;
        err = 0;
        @(negedge clk); enter_req = 1; enter_ptr = 8'h30;
        @(negedge clk); enter_req = 0; evt_valid = 1; evt_class = 4'd6; n = 1;
        @(negedge clk); evt_valid = 0; n++;
        while (busy && n < 1000) begin
            if (guest_active) err++;
            n++; @(negedge clk);
        end
        n--;
        chk(n == 42 && err == 0, "R11 held exit length", n, 42);
        chk(exit_done && exit_code == 6, "R11 held exit code", exit_code, 6);
        err = 0;
        for (int i = 0; i < NCTX; i++) if (rf[i] !== hval(8'h30, i) || mem[8'h30 + AW'(i)] !== gval(8'h30, i)) err++;
        chk(err == 0, "R11 contexts after held exit", err, 0);

        // R12 quiet while idle
        err = 0;
        repeat (5) begin @(negedge clk); if (mem_we || ctx_we) err++; end
        chk(err == 0, "R12 no writes idle", err, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule